// File: doc/BRIEF.md
# Thermometer Bubble Corrector with Boundary Locator

This block sits between a bank of 2^N-1 comparators and the code encoder of a parallel converter. A raw comparator word should read as a thermometer code: ones from bit 0 up to the level reached, and zeros above it. Offsets and metastable decisions leave stray bits, or bubbles, in that word. Each bit is rebuilt from a three-way vote among itself and its two neighbours. A single isolated error is therefore cleaned up wherever it falls.

The cleaned word is registered on the sample clock. A plain two-bit edge rule runs on it and produces a registered one-hot boundary word of 2^N bits, with bit k marking level k. The boundary output can be switched off with the `HOT_EN` parameter, and it then reads zero. Bit 0 of every word corresponds to the lowest reference.

Top module: `bubble_vote_top`

## Requirements
- R1: Inside the word, corrected bit j is 1 exactly when at least two of raw bits j-1, j and j+1 are 1.
- R2: The lowest bit votes as though a constant 1 sat below it. Raw low bits 2'b10 (bit1=1, bit0=0) therefore yield corrected bit 0 = 1.
- R3: The highest bit votes as though a constant 0 sat above it. A 1 at the top bit with a 0 below it is removed.
- R4: A clean thermometer input of any level from 0 to 2^N-1 comes out unchanged.
- R5: A single 0 just below a lone 1 near the boundary is repaired. Raw 0x02F gives 0x01F.
- R6: A lone 1 well above the boundary is cleared. Raw 0x09F gives 0x01F.
- R7: Two adjacent wrong bits are not corrected. Raw 0x067 stays 0x067, and its boundary word carries two set bits (3 and 7).
- R8: Boundary bit k (0..2^N-1) is 1 when the corrected bit k-1 is 1 and the corrected bit k is 0. A constant 1 stands below bit 0 and a constant 0 above the top bit, so a level-L clean code sets only bit L.
- R9: Both outputs are registered and reflect the input sampled one clock edge earlier.
- R10: While the active-low reset is asserted, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 2^N-1 | Raw comparator word, bit 0 lowest reference |
| therm_o | output | 2^N-1 | Registered corrected thermometer word |
| hot_o | output | 2^N | Registered one-hot boundary word (zero if HOT_EN=0) |

## Verification
On every cycle, the bound checker confirms several properties. The corrected word must equal the three-way vote on the previous input, including the fixed edge values. The boundary word must match the edge rule applied to the registered corrected word, and it must be one-hot whenever that word is a clean thermometer code. Both outputs must be zero during reset. Only the bench's scenarios show that the named bubble patterns are repaired or left alone as specified. They also show the full sweep of clean levels and that results emerge with exactly one cycle of latency in a back-to-back stream.

// File: rtl/bv_pkg.sv
package bv_pkg;
    // value assumed below bit 0 and above the top bit when voting / edge finding
    localparam logic LOW_FILL  = 1'b1;
    localparam logic HIGH_FILL = 1'b0;
endpackage

// File: rtl/bv_maj3.sv
module bv_maj3 (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic y_o
);
    always_comb begin
        y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/bv_vote_net.sv
module bv_vote_net #(
    parameter int WIDTH = 15
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] voted_o
);
    import bv_pkg::*;

    // raw word extended by one fill bit at each end
    logic [WIDTH+1:0] ext;

    always_comb begin
        ext = {HIGH_FILL, raw_i, LOW_FILL};
    end

    for (genvar j = 0; j < WIDTH; j++) begin : g_vote
        bv_maj3 u_maj (
            .a_i (ext[j]),
            .b_i (ext[j+1]),
            .c_i (ext[j+2]),
            .y_o (voted_o[j])
        );
    end
endmodule

// File: rtl/bv_edge_onehot.sv
module bv_edge_onehot #(
    parameter int WIDTH = 15
) (
    input  logic [WIDTH-1:0] therm_i,
    output logic [WIDTH:0]   hot_o
);
    import bv_pkg::*;

    logic [WIDTH+1:0] ext;

    always_comb begin
        ext = {HIGH_FILL, therm_i, LOW_FILL};
    end

    // level k boundary: bit below is set, bit k itself is clear
    for (genvar k = 0; k <= WIDTH; k++) begin : g_edge
        assign hot_o[k] = ext[k] & ~ext[k+1];
    end
endmodule

// File: rtl/bubble_vote_top.sv
module bubble_vote_top #(
    parameter int N      = 4,
    parameter bit HOT_EN = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [(1<<N)-2:0]    raw_i,
    output logic [(1<<N)-2:0]    therm_o,
    output logic [(1<<N)-1:0]    hot_o
);
    localparam int W = (1 << N) - 1;
    localparam int H = W + 1;

    typedef struct packed {
        logic [W-1:0] therm;
        logic [H-1:0] hot;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] voted;
    logic [H-1:0] hot_raw;
    logic [H-1:0] hot_sel;

    bv_vote_net #(.WIDTH(W)) u_vote (
        .raw_i   (raw_i),
        .voted_o (voted)
    );

    generate
        if (HOT_EN) begin : g_hot
            bv_edge_onehot #(.WIDTH(W)) u_edge (
                .therm_i (voted),
                .hot_o   (hot_raw)
            );
            assign hot_sel = hot_raw;
        end else begin : g_nohot
            assign hot_raw = '0;
            assign hot_sel = '0;
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.therm = voted;
        st_d.hot   = hot_sel;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign therm_o = st_q.therm;
    assign hot_o   = st_q.hot;
endmodule

// File: rtl/bubble_vote_chk.sv
module bubble_vote_chk #(
    parameter int N      = 4,
    parameter bit HOT_EN = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [(1<<N)-2:0] raw_i,
    input logic [(1<<N)-2:0] therm_o,
    input logic [(1<<N)-1:0] hot_o
);
    localparam int W = (1 << N) - 1;

    logic live_q;  // set once a post-reset edge has loaded the outputs

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    function automatic logic [W-1:0] vote_ref(input logic [W-1:0] r);
        logic [W+1:0] e;
        logic [W-1:0] v;
        e = {1'b0, r, 1'b1};
        for (int j = 0; j < W; j++) begin
            v[j] = ({30'd0, e[j]} + {30'd0, e[j+1]} + {30'd0, e[j+2]}) >= 32'd2;
        end
        return v;
    endfunction

    function automatic logic [W:0] edge_ref(input logic [W-1:0] t);
        logic [W:0] h;
        for (int k = 0; k <= W; k++) begin
            h[k] = ((k == 0) ? 1'b1 : t[k-1]) & ((k == W) ? 1'b1 : ~t[k]);
        end
        return h;
    endfunction

    function automatic logic is_therm(input logic [W-1:0] t);
        return ({1'b0, t} & ({1'b0, t} + 1'b1)) == '0;
    endfunction

    // R1, R9: registered output is the vote on the prior input
    a_r1_vote_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q |-> therm_o == vote_ref($past(raw_i)));

    // R2: constant 1 below bit 0
    a_r2_low_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(raw_i[1:0]) == 2'b10) |-> therm_o[0]);

    // R3: constant 0 above the top bit
    a_r3_high_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(raw_i[W-1:W-2]) == 2'b10) |-> !therm_o[W-1]);

    // R4: clean code passes through
    a_r4_clean_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && is_therm($past(raw_i))) |-> therm_o == $past(raw_i));

    // R8: boundary word follows the corrected word
    a_r8_edge_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && HOT_EN) |-> hot_o == edge_ref(therm_o));

    a_r8_single_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && HOT_EN && is_therm(therm_o)) |-> $onehot0(hot_o) && hot_o != '0);

    // R10: outputs cleared under reset
    a_r10_reset_zero: assert property (@(posedge clk_i)
        !rst_ni |-> (therm_o == '0 && hot_o == '0));
endmodule

bind bubble_vote_top bubble_vote_chk #(.N(N), .HOT_EN(HOT_EN)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw_i),
    .therm_o (therm_o),
    .hot_o   (hot_o)
);

// File: tb/bubble_vote_top_tb.sv
module bubble_vote_top_tb;
    localparam int N      = 4;
    localparam int W      = (1 << N) - 1;
    localparam int PERIOD = 10;

    logic         clk_i = 1'b0;
    logic         rst_ni;
    logic [W-1:0] raw_i = '0;
    logic [W-1:0] therm_o;
    logic [W:0]   hot_o;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    typedef struct {
        logic [W-1:0] therm;
        logic [W:0]   hot;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    bubble_vote_top #(.N(N), .HOT_EN(1'b1)) u_dut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_i   (raw_i),
        .therm_o (therm_o),
        .hot_o   (hot_o)
    );

    always #(PERIOD/2) clk_i = ~clk_i;

    // reference boundary from R8
    function automatic logic [W:0] hot_of(input logic [W-1:0] t);
        logic [W:0] h;
        for (int k = 0; k <= W; k++) begin
            h[k] = ((k == 0) ? 1'b1 : t[k-1]) & ((k == W) ? 1'b1 : ~t[k]);
        end
        return h;
    endfunction

    // reference vote from R1..R3
    function automatic logic [W-1:0] vote_of(input logic [W-1:0] r);
        logic [W-1:0] v;
        for (int j = 0; j < W; j++) begin
            int ones;
            ones = int'(r[j]);
            ones += (j == 0)     ? 1 : int'(r[j-1]);
            ones += (j == W - 1) ? 0 : int'(r[j+1]);
            v[j] = (ones >= 2);
        end
        return v;
    endfunction

    task automatic drive(input logic [W-1:0] raw, input logic [W-1:0] exp_t_word, input string tag);
        exp_t e;
        @(negedge clk_i);
        raw_i   = raw;
        e.therm = exp_t_word;
        e.hot   = hot_of(exp_t_word);
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic check_hot(input logic [W:0] act, input logic [W:0] expv, input string tag);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s boundary: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor: one result per pushed item, one cycle later
    always @(posedge clk_i) begin
        #2;
        if (rst_ni && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compared++;
            if (therm_o !== e.therm) begin
                mismatched++;
                $display("FAIL %s corrected: actual %h expected %h", e.tag, therm_o, e.therm);
            end
            check_hot(hot_o, e.hot, e.tag);
        end
    end

    initial begin
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        // R10: zero under reset
        compared++;
        if (therm_o !== '0 || hot_o !== '0) begin
            mismatched++;
            $display("FAIL R10 reset: actual %h/%h expected 0/0", therm_o, hot_o);
        end
        rst_ni = 1'b1;

        // R4, R8: every clean level, boundary sets only bit L
        for (int L = 0; L <= W; L++) begin
            logic [W:0] t;
            t = (W+1)'((1 << L) - 1);
            drive(t[W-1:0], t[W-1:0], "R4/R8 clean level");
        end
        // R5 lone zero near boundary
        drive(15'h002F, 15'h001F, "R5 lone zero");
        // R6 lone one far above boundary
        drive(15'h009F, 15'h001F, "R6 lone one");
        // R7 adjacent errors survive, two boundary bits (3 and 7)
        drive(15'h0067, 15'h0067, "R7 double error");
        // R2 bottom edge
        drive(15'h0002, 15'h0001, "R2 low edge");
        drive(15'h0000, 15'h0000, "R2 all zero");
        // R3 top edge
        drive(15'h40FF, 15'h00FF, "R3 top lone one");
        drive(15'h5FFF, 15'h3FFF, "R3 top gap");
        drive(15'h7FFF, 15'h7FFF, "R3 full scale");
        // R9 alternating stream, back to back
        for (int i = 0; i < 6; i++) begin
            drive((i % 2) ? 15'h007F : 15'h0003, (i % 2) ? 15'h007F : 15'h0003, "R9 latency");
        end
        // R1 pseudo-random words against the vote rule
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] r;
            r = W'($urandom);
            drive(r, vote_of(r), "R1 random");
        end

        @(negedge clk_i);
        raw_i = '0;
        repeat (3) @(negedge clk_i);
        // guard against lost scoreboard items
        compared++;
        if (sb_q.size() != 0) begin
            mismatched++;
            $display("FAIL R9 pending items: actual %0d expected 0", sb_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule